// File: doc/BRIEF.md
# Multi-Edge Compare PWM Submodule

This block is one timer slice for pulse-width generation. A 16-bit up-counter runs from a start value to a modulus value and then restarts from the start value. Six edge registers are each compared against the running count. The comparators work in pairs, and each pair drives one set/clear output flop. The result is three pulse outputs, and software places both edges of every one of them. The first pair also marks the mid-period point. When the mid-period reload is not needed, the third output serves as a spare pulse channel.

Each comparator also acts as an output-compare source. It emits a one-cycle trigger pulse when it starts matching, and it sets a sticky interrupt flag that has its own enable. Software writes into shadow registers. Those values take effect only at a reload point, so a period that is already running is never disturbed. To get a one-shot output compare, place the clearing edge beyond the modulus; the output then stays high once it has been set.

Top module: `pwm_edge_sub`

## Requirements
- R1: Writes with `wr_en` high land by address. Addresses 0 to 5 hold the shadows of edge values E0 to E5. Address 6 holds the start value. Address 7 bit 0 enables mid-period reload. Address 8 bits [5:0] are the per-compare interrupt enables. Address 9 bits [5:0] clear the interrupt flags, where writing 1 clears the flag.
- R2: While `run` is low, `cnt` is loaded with the start-value shadow, all three outputs are driven to 0, and the active edge values follow their shadows.
- R3: While `run` is high, `cnt` increases by one each cycle. In a cycle where `cnt` >= active E1, the next count is the start value, and all shadows become active on that same edge.
- R4: Compare i matches while `run` is high and `cnt` >= active Ei, compared as unsigned values. It is a magnitude comparison, not an equality test.
- R5: `pwm_x` is set by match 0 and cleared by match 1. `pwm_a` uses matches 2 and 3, and `pwm_b` uses matches 4 and 5. Each output is registered one cycle after the count that causes it. If set and clear are active together, the output goes to 0. If neither is active, the output holds its value.
- R6: If an output's clear value lies above E1, the output stays high once it has been set (one-shot high). If its set value lies above E1, the output is never set.
- R7: `trig[i]` is high for exactly one cycle, in the cycle after match i goes from false to true. In steady running this gives one pulse per period when start < Ei <= E1, and no pulse otherwise.
- R8: `half_tick` pulses for one cycle in the cycle after match 0 rises.
- R9: With mid-period reload enabled, the shadows also become active on the edge where match 0 rises.
- R10: A shadow write made during a period has no effect on the outputs until the next reload point.
- R11: Each flag in `irq_flags` is set when its match rises, and it stays set until it is cleared through address 9. `irq` is the OR of all flags that are set and enabled.
- R12: After reset, all registers are zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter run enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| cnt | output | 16 | Current timer count |
| pwm_x | output | 1 | Auxiliary / sync output (edges E0, E1) |
| pwm_a | output | 1 | Output A (edges E2, E3) |
| pwm_b | output | 1 | Output B (edges E4, E5) |
| trig | output | 6 | Per-compare trigger pulses |
| half_tick | output | 1 | Mid-period pulse |
| irq_flags | output | 6 | Sticky compare flags |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The hardest case to reach is a shadow write that lands in the middle of a running period. The result must depend on whether mid-period reload is enabled. The stimulus first syncs to the count that the block exposes. It writes a new clearing edge a few counts before the midpoint. It then samples `pwm_a` just after the old clearing edge would have fired, once with mid-period reload disabled and once with it enabled. The results must differ between the two runs. Cases with simultaneous set and clear and cases with out-of-range edges come from a vector table. Each entry in that table counts high cycles per period, and its expected values separate a magnitude comparator from an equality one.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
  parameter int CW   = 16;
  parameter int NCMP = 6;
  parameter int AW   = 4;

  // Set/clear flop rule: clear dominates, so set+clear gives 0.
  function automatic logic sr_next(input logic q, input logic s, input logic r);
    if (r) return 1'b0;
    if (s) return 1'b1;
    return q;
  endfunction
endpackage

// File: rtl/pwm_edge_regs.sv
module pwm_edge_regs
  import pwm_edge_pkg::*;
#(
  parameter int P_CW   = CW,
  parameter int P_NCMP = NCMP,
  parameter int P_AW   = AW
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [P_AW-1:0]              wr_addr,
  input  logic [P_CW-1:0]              wr_data,
  output logic [P_NCMP-1:0][P_CW-1:0]  val_buf,
  output logic [P_CW-1:0]              init_buf,
  output logic                         half_en,
  output logic [P_NCMP-1:0]            ien,
  output logic [P_NCMP-1:0]            clr_pls
);
  localparam int A_INIT = P_NCMP;
  localparam int A_CTRL = P_NCMP + 1;
  localparam int A_IEN  = P_NCMP + 2;
  localparam int A_CLR  = P_NCMP + 3;

  for (genvar i = 0; i < P_NCMP; i++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                val_buf[i] <= '0;
      else if (wr_en && wr_addr == P_AW'(i))     val_buf[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_buf <= '0;
      half_en  <= 1'b0;
      ien      <= '0;
    end else if (wr_en) begin
      if (wr_addr == P_AW'(A_INIT)) init_buf <= wr_data;
      if (wr_addr == P_AW'(A_CTRL)) half_en  <= wr_data[0];
      if (wr_addr == P_AW'(A_IEN))  ien      <= wr_data[P_NCMP-1:0];
    end
  end

  assign clr_pls = (wr_en && wr_addr == P_AW'(A_CLR)) ? wr_data[P_NCMP-1:0] : '0;
endmodule

// File: rtl/pwm_edge_timer.sv
module pwm_edge_timer
  import pwm_edge_pkg::*;
#(
  parameter int P_CW   = CW,
  parameter int P_NCMP = NCMP
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  input  logic [P_NCMP-1:0][P_CW-1:0]  val_buf,
  input  logic [P_CW-1:0]              init_buf,
  input  logic                         half_en,
  output logic [P_CW-1:0]              cnt,
  output logic [P_NCMP-1:0]            hit,
  output logic [P_NCMP-1:0]            rise,
  output logic                         full_rld,
  output logic                         half_ld
);
  localparam int MOD_IDX  = 1;
  localparam int HALF_IDX = 0;

  logic [P_NCMP-1:0][P_CW-1:0] val_act;
  logic [P_NCMP-1:0]           hit_q;

  function automatic logic [P_CW-1:0] step_cnt(input logic [P_CW-1:0] c,
                                               input logic [P_CW-1:0] start,
                                               input logic wrap);
    return wrap ? start : c + 1'b1;
  endfunction

  for (genvar i = 0; i < P_NCMP; i++) begin : g_cmp
    assign hit[i]  = run && (cnt >= val_act[i]);
    assign rise[i] = hit[i] && !hit_q[i];
  end

  assign full_rld = hit[MOD_IDX];
  assign half_ld  = half_en && rise[HALF_IDX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      val_act <= '0;
      hit_q   <= '0;
    end else if (!run) begin
      cnt     <= init_buf;
      val_act <= val_buf;
      hit_q   <= '0;
    end else begin
      cnt   <= step_cnt(cnt, init_buf, full_rld);
      hit_q <= hit;
      if (full_rld || half_ld) val_act <= val_buf;
    end
  end
endmodule

// File: rtl/pwm_edge_pair.sv
module pwm_edge_pair
  import pwm_edge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic set_hit,
  input  logic clr_hit,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (!run) q <= 1'b0;
    else           q <= sr_next(q, set_hit, clr_hit);
  end
endmodule

// File: rtl/pwm_edge_sub.sv
module pwm_edge_sub
  import pwm_edge_pkg::*;
#(
  parameter int P_CW   = CW,
  parameter int P_NCMP = NCMP,
  parameter int P_AW   = AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_en,
  input  logic [P_AW-1:0]   wr_addr,
  input  logic [P_CW-1:0]   wr_data,
  output logic [P_CW-1:0]   cnt,
  output logic              pwm_x,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic [P_NCMP-1:0] trig,
  output logic              half_tick,
  output logic [P_NCMP-1:0] irq_flags,
  output logic              irq
);
  localparam int NOUT = P_NCMP / 2;

  logic [P_NCMP-1:0][P_CW-1:0] val_buf;
  logic [P_CW-1:0]             init_buf;
  logic                        half_en;
  logic [P_NCMP-1:0]           ien;
  logic [P_NCMP-1:0]           clr_pls;
  logic [P_NCMP-1:0]           hit;
  logic [P_NCMP-1:0]           rise;
  logic                        full_rld;
  logic                        half_ld;
  logic [NOUT-1:0]             pwm_vec;

  pwm_edge_regs #(.P_CW(P_CW), .P_NCMP(P_NCMP), .P_AW(P_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .val_buf(val_buf), .init_buf(init_buf), .half_en(half_en), .ien(ien),
    .clr_pls(clr_pls)
  );

  pwm_edge_timer #(.P_CW(P_CW), .P_NCMP(P_NCMP)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .val_buf(val_buf), .init_buf(init_buf),
    .half_en(half_en), .cnt(cnt), .hit(hit), .rise(rise), .full_rld(full_rld),
    .half_ld(half_ld)
  );

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    pwm_edge_pair u_pair (
      .clk(clk), .rst_n(rst_n), .run(run),
      .set_hit(hit[2*k]), .clr_hit(hit[2*k+1]), .q(pwm_vec[k])
    );
  end

  assign pwm_x = pwm_vec[0];
  assign pwm_a = pwm_vec[1];
  assign pwm_b = pwm_vec[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig      <= '0;
      half_tick <= 1'b0;
      irq_flags <= '0;
    end else begin
      trig      <= rise;
      half_tick <= rise[0];
      irq_flags <= (irq_flags & ~clr_pls) | rise;
    end
  end

  assign irq = |(irq_flags & ien);
endmodule

// File: rtl/pwm_edge_sub_chk.sv
module pwm_edge_sub_chk #(
  parameter int P_CW   = 16,
  parameter int P_NCMP = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [P_CW-1:0]   cnt,
  input logic [P_CW-1:0]   init_buf,
  input logic              full_rld,
  input logic              set_a,
  input logic              clr_a,
  input logic              pwm_a,
  input logic              pwm_b,
  input logic              pwm_x,
  input logic [P_NCMP-1:0] trig,
  input logic [P_NCMP-1:0] irq_flags,
  input logic [P_NCMP-1:0] clr_pls
);
  // R2: stopped timer reloads the start value and silences every output
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == $past(init_buf) && !pwm_a && !pwm_b && !pwm_x));

  // R3: counting step between reload points
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !full_rld) |=> cnt == $past(cnt) + 1'b1);

  // R3: wrap to the start value at the modulus
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && full_rld) |=> cnt == $past(init_buf));

  // R5: simultaneous set and clear forces output A low
  a_r5_both_low: assert property (@(posedge clk) disable iff (!rst_n)
    (set_a && clr_a) |=> !pwm_a);

  for (genvar i = 0; i < P_NCMP; i++) begin : g_chk
    // R7: trigger pulse lasts one cycle
    a_r7_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
      trig[i] |=> !trig[i]);
    // R11: flags stay set until cleared
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flags[i] && !clr_pls[i]) |=> irq_flags[i]);
  end
endmodule

bind pwm_edge_sub pwm_edge_sub_chk #(.P_CW(P_CW), .P_NCMP(P_NCMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .init_buf(init_buf),
  .full_rld(full_rld), .set_a(hit[2]), .clr_a(hit[3]), .pwm_a(pwm_a),
  .pwm_b(pwm_b), .pwm_x(pwm_x), .trig(trig), .irq_flags(irq_flags),
  .clr_pls(clr_pls)
);

// File: tb/pwm_edge_sub_bench.sv
module pwm_edge_sub_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt;
  logic        pwm_x, pwm_a, pwm_b, half_tick, irq;
  logic [5:0]  trig, irq_flags;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwm_edge_sub u_pwm_edge_sub (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt(cnt), .pwm_x(pwm_x), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .trig(trig), .half_tick(half_tick), .irq_flags(irq_flags), .irq(irq)
  );

  // start, E0..E5, high-count x, a, b, trig2 pulses, half pulses (per period)
  localparam int NV = 4;
  localparam int VT [NV][12] = '{
    '{0,   5,   9,   2,   6,   0,   3,   4, 4, 3,  1, 1},
    '{10,  18,  25,  12,  12,  20,  30,  7, 0, 16, 1, 1},
    '{100, 101, 103, 200, 102, 103, 100, 2, 0, 0,  0, 1},
    '{0,   1,   1,   0,   1,   1,   2,   0, 1, 2,  0, 1}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cnt(input int k);
    for (int g = 0; g < 1000 && cnt != 16'(k); g++) step();
  endtask

  task automatic load_vec(input int v, input int half);
    run = 1'b0;
    step();
    wr(7, half);
    wr(6, VT[v][0]);
    for (int i = 0; i < 6; i++) wr(i, VT[v][1+i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R12: reset state
    chk("R12 cnt", int'(cnt), 0);
    chk("R12 outputs", int'({pwm_x, pwm_a, pwm_b, half_tick, irq}), 0);
    chk("R12 flags/trig", int'({irq_flags, trig}), 0);
    rst_n = 1'b1;
    step();

    // Vector table: R1 R4 R5 R6 R7 R8 (per-period high counts and pulses)
    for (int v = 0; v < NV; v++) begin
      int per, sx, sa, sb, st, sh;
      per = VT[v][2] - VT[v][0] + 1;
      load_vec(v, 0);
      run = 1'b1;
      repeat (3 * per + 2) step();
      sx = 0; sa = 0; sb = 0; st = 0; sh = 0;
      for (int c = 0; c < per; c++) begin
        sx += int'(pwm_x); sa += int'(pwm_a); sb += int'(pwm_b);
        st += int'(trig[2]); sh += int'(half_tick);
        step();
      end
      chk($sformatf("R5 vec%0d pwm_x highs", v), sx, VT[v][7]);
      chk($sformatf("R4 R6 vec%0d pwm_a highs", v), sa, VT[v][8]);
      chk($sformatf("R4 R6 vec%0d pwm_b highs", v), sb, VT[v][9]);
      chk($sformatf("R7 vec%0d trig2 pulses", v), st, VT[v][10]);
      chk($sformatf("R8 vec%0d half pulses", v), sh, VT[v][11]);
    end

    // R2 and R3: idle and wrap, on vector 1 (start 10, modulus 25)
    load_vec(1, 0);
    run = 1'b1;
    repeat (40) step();
    chk("R5 pwm_b one-shot high", int'(pwm_b), 1);
    run = 1'b0;
    step();
    chk("R2 cnt holds start", int'(cnt), 10);
    chk("R2 outputs low", int'({pwm_x, pwm_a, pwm_b}), 0);
    run = 1'b1;
    wait_cnt(25);
    step();
    chk("R3 wrap to start", int'(cnt), 10);
    step();
    chk("R3 increment", int'(cnt), 11);

    // R10: mid-period write waits for full reload
    load_vec(0, 0);
    run = 1'b1;
    repeat (12) step();
    wait_cnt(3);
    wr(3, 8);
    wait_cnt(7);
    chk("R10 old E3 still active", int'(pwm_a), 0);
    wait_cnt(0);
    wait_cnt(7);
    chk("R3 new E3 after reload", int'(pwm_a), 1);

    // R9 and R8: mid-period reload applies the write at the E0 point
    load_vec(0, 1);
    run = 1'b1;
    step();
    wait_cnt(1);
    wr(3, 8);
    wait_cnt(6);
    chk("R8 half_tick after E0", int'(half_tick), 1);
    step();
    chk("R9 new E3 at midpoint", int'(pwm_a), 1);
    chk("R8 half_tick one cycle", int'(half_tick), 0);

    // R11: sticky flags, enables, write-1-to-clear
    load_vec(0, 0);
    wr(8, 0);
    wr(9, 6'h3F);
    run = 1'b1;
    repeat (25) step();
    chk("R11 flag2 set", int'(irq_flags[2]), 1);
    chk("R11 irq masked", int'(irq), 0);
    wr(8, 4);
    chk("R11 irq enabled", int'(irq), 1);
    run = 1'b0;
    step();
    wr(9, 4);
    chk("R11 flag2 cleared", int'(irq_flags[2]), 0);
    chk("R11 irq after clear", int'(irq), 0);
    chk("R11 flag3 untouched", int'(irq_flags[3]), 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule